// File: doc/BRIEF.md
# Quad-Data-Rate Burst-of-Two Static Memory

This block is a synthesizable behavioural model of a static memory whose read and write data travel on separate buses. Both buses move data on both phases of their clocks. Every command, read or write, moves a pair of words. One address bus is shared by the two directions. The read address is taken on the rising edge of the input clock `k`. The write address is taken on the rising edge of its complement `kN`, half a cycle later. This lets a read and a write be issued together in every cycle.

Write data arrive in early-write fashion. The first word of a pair is taken on the same `k` edge as the write command, and the second word on the following `kN` edge. Each 9-bit lane of each word has its own active-low enable. Read data leave one cycle after the command. The first word appears on the next output-clock rise and the second on the complementary output-clock rise. Two kinds of output clock are supported:
- A dedicated clock pair `c`/`cN`.
- When both `c` and `cN` are held high, the input clocks `k`/`kN` take their place.

The echo clocks always copy whichever pair is active. When no read follows, an output-enable flag drops once the burst in flight has finished.

Top module: `qdr_b2_sram`

## Requirements
- R1: A read command is taken when `rdSelN` is low at a rising edge of `k`. The value of `addr` at that edge selects a word pair. The burst returns word `2*addr` first and word `2*addr+1` second.
- R2: For a read taken at `k` edge n, `oe` is high and `dout` shows the first word from the output-clock rise coinciding with `k` edge n+1. `dout` shows the second word from the following complementary output-clock rise.
- R3: Reads taken on consecutive `k` edges give an unbroken stream: `oe` stays high, and a new word appears on each rise of either output clock.
- R4: When `c` and `cN` are both held at 1, output timing and the echo clocks `cq`/`cqN` follow `k`/`kN`. Otherwise they follow `c`/`cN`. In both cases `cq` equals the active rising-phase clock and `cqN` its complement.
- R5: A write command is taken when `wrSelN` is low at a rising edge of `k`. The first data word is taken on that same edge. The write address and the second data word are taken on the next `kN` rising edge.
- R6: `byteWrN` is active low, sampled with each data word, and has one bit per 9-bit lane: bit i guards data bits 9i+8 down to 9i. A lane whose bit is 1 keeps its old contents.
- R7: Data and address on the bus in a cycle where `wrSelN` is high at the `k` edge leave the array unchanged.
- R8: `oe` is 0 during reset. After a burst with no read command on the next `k` edge, `oe` returns to 0 at the following rising-phase output-clock edge.
- R9: When a read and a write to the same pair are taken on the same `k` edge, the read returns the contents from before that write.
- R10: A pair written in one cycle is returned by a read taken on the next `k` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| k | input | 1 | Input clock, rising phase |
| kN | input | 1 | Input clock, complementary phase |
| c | input | 1 | Output clock, rising phase (tie high with `cN` to use `k`) |
| cN | input | 1 | Output clock, complementary phase |
| rstN | input | 1 | Asynchronous active-low reset of control and output state |
| rdSelN | input | 1 | Active-low read command |
| wrSelN | input | 1 | Active-low write command |
| addr | input | ADDR_W | Shared address: read pair at `k`, write pair at `kN` |
| din | input | WORD_W | Write data, one word per clock phase |
| byteWrN | input | WORD_W/9 | Active-low per-lane write enables |
| dout | output | WORD_W | Read data, one word per output-clock phase |
| oe | output | 1 | High while `dout` carries a read burst |
| cq | output | 1 | Echo of the active rising-phase output clock |
| cqN | output | 1 | Echo of the active complementary output clock |

## Verification
The stimuli cover several cases:
- Isolated reads after writes, which pin down the latency and the order of the two words.
- Runs of back-to-back reads, which separate a continuous stream from one that drops `oe` between bursts.
- Partial lane masks that differ between the two words of a burst, which show whether each lane and each word phase is guarded on its own.
- A write cycle with `wrSelN` high but live data and address, which exposes any write that ignores the command.

A read and a write to the same pair in one cycle separates read-before-write from read-after-write. The whole sequence is repeated with `c`/`cN` tied high, to show that output timing and the echo clocks move over to `k`/`kN`.

// File: rtl/qdr_pkg.sv
`timescale 1ns/1ps
package qdr_pkg;
  localparam int LANE_W = 9;

  // Strobes from control to datapath; each names the clock it is used on.
  typedef struct packed {
    logic rdCapture;  // used at k rise: fetch the addressed pair
    logic wrLoad;     // used at k rise: hold first write word
    logic wrCommit;   // used at kN rise: write both words
    logic launch;     // used at output-clock rise: start a burst
  } qdrStrobes_t;
endpackage

// File: rtl/qdr_ctrl.sv
`timescale 1ns/1ps
module qdr_ctrl
  import qdr_pkg::*;
(
  input  logic        k,
  input  logic        kN,
  input  logic        rstN,
  input  logic        rdSelN,
  input  logic        wrSelN,
  output qdrStrobes_t strobes
);
  logic rdPend;
  logic wrPend;
  logic launchValid;

  // Commands are sampled on the rising edge of k.
  always_ff @(posedge k or negedge rstN) begin
    if (!rstN) begin
      rdPend <= 1'b0;
      wrPend <= 1'b0;
    end else begin
      rdPend <= !rdSelN;
      wrPend <= !wrSelN;
    end
  end

  // A pending read moves to the output side half a cycle later.
  always_ff @(posedge kN or negedge rstN) begin
    if (!rstN) launchValid <= 1'b0;
    else       launchValid <= rdPend;
  end

  assign strobes.rdCapture = !rdSelN;
  assign strobes.wrLoad    = !wrSelN;
  assign strobes.wrCommit  = wrPend;
  assign strobes.launch    = launchValid;

  // R1: a read seen at k is still pending at the next k edge
  a_r1_read_tracked: assert property (@(posedge k) disable iff (!rstN)
    !rdSelN |=> rdPend);
  // R5: a write seen at k commits at the following kN edge
  a_r5_write_tracked: assert property (@(posedge k) disable iff (!rstN)
    !wrSelN |=> wrPend);
endmodule

// File: rtl/qdr_datapath.sv
`timescale 1ns/1ps
module qdr_datapath
  import qdr_pkg::*;
#(
  parameter int WORD_W = 36,
  parameter int ADDR_W = 4
) (
  input  logic                      k,
  input  logic                      kN,
  input  logic                      outClk0,
  input  logic                      outClk1,
  input  logic                      rstN,
  input  qdrStrobes_t               strobes,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [WORD_W-1:0]         din,
  input  logic [WORD_W/LANE_W-1:0]  byteWrN,
  output logic [WORD_W-1:0]         dout,
  output logic                      oe
);
  localparam int LANES = WORD_W / LANE_W;
  localparam int WORDS = 2 ** (ADDR_W + 1);

  logic [WORD_W-1:0] mem [WORDS];
  logic [WORD_W-1:0] word0Reg;
  logic [LANES-1:0]  be0Reg;
  logic [WORD_W-1:0] rdBuf0, rdBuf1;
  logic [WORD_W-1:0] launchBuf0, launchBuf1;
  logic [WORD_W-1:0] phase0Out, phase1Out, secondReg;
  logic              oeReg;

  // k rise: hold the early write word and snapshot the read pair.
  // The snapshot precedes the kN write, so same-cycle reads see old data.
  always_ff @(posedge k) begin
    if (strobes.wrLoad) begin
      word0Reg <= din;
      be0Reg   <= byteWrN;
    end
    if (strobes.rdCapture) begin
      rdBuf0 <= mem[{addr, 1'b0}];
      rdBuf1 <= mem[{addr, 1'b1}];
    end
  end

  // kN rise: commit both write words lane by lane.
  always_ff @(posedge kN) begin
    if (strobes.wrCommit) begin
      for (int l = 0; l < LANES; l++) begin
        if (!be0Reg[l])
          mem[{addr, 1'b0}][l*LANE_W +: LANE_W] <= word0Reg[l*LANE_W +: LANE_W];
        if (!byteWrN[l])
          mem[{addr, 1'b1}][l*LANE_W +: LANE_W] <= din[l*LANE_W +: LANE_W];
      end
    end
  end

  // Hand the pair to the output side half a cycle before launch.
  always_ff @(posedge kN) begin
    launchBuf0 <= rdBuf0;
    launchBuf1 <= rdBuf1;
  end

  // Rising-phase output clock: first word and output enable.
  always_ff @(posedge outClk0 or negedge rstN) begin
    if (!rstN) begin
      oeReg     <= 1'b0;
      phase0Out <= '0;
      secondReg <= '0;
    end else begin
      oeReg <= strobes.launch;
      if (strobes.launch) begin
        phase0Out <= launchBuf0;
        secondReg <= launchBuf1;
      end
    end
  end

  // Complementary output clock: second word.
  always_ff @(posedge outClk1 or negedge rstN) begin
    if (!rstN)      phase1Out <= '0;
    else if (oeReg) phase1Out <= secondReg;
  end

  assign dout = outClk0 ? phase0Out : phase1Out;
  assign oe   = oeReg;

  // R2: a launched burst raises the output enable
  a_r2_burst_enables: assert property (@(posedge outClk0) disable iff (!rstN)
    strobes.launch |=> oe);
  // R8: without a new burst the output is deselected
  a_r8_deselect: assert property (@(posedge outClk0) disable iff (!rstN)
    !strobes.launch |=> !oe);
endmodule

// File: rtl/qdr_b2_sram.sv
`timescale 1ns/1ps
module qdr_b2_sram
  import qdr_pkg::*;
#(
  parameter int WORD_W = 36,
  parameter int ADDR_W = 4
) (
  input  logic                      k,
  input  logic                      kN,
  input  logic                      c,
  input  logic                      cN,
  input  logic                      rstN,
  input  logic                      rdSelN,
  input  logic                      wrSelN,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [WORD_W-1:0]         din,
  input  logic [WORD_W/LANE_W-1:0]  byteWrN,
  output logic [WORD_W-1:0]         dout,
  output logic                      oe,
  output logic                      cq,
  output logic                      cqN
);
  qdrStrobes_t strobes;
  logic        useK;
  logic        outClk0, outClk1;

  // Both output clocks high at once only happens when they are tied off.
  assign useK    = c & cN;
  assign outClk0 = useK ? k  : c;
  assign outClk1 = useK ? kN : cN;
  assign cq      = outClk0;
  assign cqN     = outClk1;

  qdr_ctrl uCtrl (
    .k       (k),
    .kN      (kN),
    .rstN    (rstN),
    .rdSelN  (rdSelN),
    .wrSelN  (wrSelN),
    .strobes (strobes)
  );

  qdr_datapath #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) uData (
    .k       (k),
    .kN      (kN),
    .outClk0 (outClk0),
    .outClk1 (outClk1),
    .rstN    (rstN),
    .strobes (strobes),
    .addr    (addr),
    .din     (din),
    .byteWrN (byteWrN),
    .dout    (dout),
    .oe      (oe)
  );
endmodule

// File: tb/tb_qdr_b2_sram.sv
`timescale 1ns/1ps
module tb_qdr_b2_sram;
  localparam int WORD_W = 36;
  localparam int ADDR_W = 4;
  localparam int LANES  = WORD_W / 9;

  logic k = 1'b0;
  logic kN, c, cN, rstN, rdSelN, wrSelN, oe, cq, cqN;
  logic tied = 1'b0;
  logic [ADDR_W-1:0] addr;
  logic [WORD_W-1:0] din, dout;
  logic [LANES-1:0]  byteWrN;

  always #10 k = ~k;  // 50 MHz
  assign kN = ~k;
  assign c  = tied ? 1'b1 : k;
  assign cN = tied ? 1'b1 : kN;

  qdr_b2_sram #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) dut (
    .k(k), .kN(kN), .c(c), .cN(cN), .rstN(rstN), .rdSelN(rdSelN),
    .wrSelN(wrSelN), .addr(addr), .din(din), .byteWrN(byteWrN),
    .dout(dout), .oe(oe), .cq(cq), .cqN(cqN)
  );

  int checks = 0, errors = 0, edgeCnt = 0;
  bit done = 0, monOn = 0;
  logic [WORD_W-1:0] model [0:31];
  bit               expValid [0:4095];
  logic [WORD_W-1:0] expW0 [0:4095];
  logic [WORD_W-1:0] expW1 [0:4095];
  string            expTag [0:4095];

  always @(posedge k) edgeCnt++;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [WORD_W-1:0] pat(input int a, input int s);
    return {4'(s), 32'(a * 32'h01010101 + s * 32'h00100037 + 32'h5a5a0000)};
  endfunction

  function automatic logic [WORD_W-1:0] merge(input logic [WORD_W-1:0] old,
      input logic [WORD_W-1:0] nw, input logic [LANES-1:0] bw);
    logic [WORD_W-1:0] r = old;
    for (int l = 0; l < LANES; l++)
      if (!bw[l]) r[l*9 +: 9] = nw[l*9 +: 9];
    return r;
  endfunction

  // One k cycle: read phase driven before the k rise, write phase before kN rise.
  task automatic doCycle(input bit rd, input int ra, input bit wr, input int wa,
      input logic [WORD_W-1:0] d0, input logic [WORD_W-1:0] d1,
      input logic [LANES-1:0] b0, input logic [LANES-1:0] b1, input string tag);
    @(posedge kN); #5;
    rdSelN = !rd; wrSelN = !wr; addr = ADDR_W'(ra); din = d0; byteWrN = b0;
    @(posedge k); #5;
    if (rd) begin
      expValid[edgeCnt] = 1'b1;
      expW0[edgeCnt] = model[2*ra];
      expW1[edgeCnt] = model[2*ra+1];
      expTag[edgeCnt] = tag;
    end
    if (wr) begin
      model[2*wa]   = merge(model[2*wa], d0, b0);
      model[2*wa+1] = merge(model[2*wa+1], d1, b1);
    end
    rdSelN = 1'b1; wrSelN = 1'b1; addr = ADDR_W'(wa); din = d1; byteWrN = b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) doCycle(0, 0, 0, 0, '0, '0, '1, '1, "");
  endtask

  task automatic wrPair(input int a, input int s);
    doCycle(0, 0, 1, a, pat(a, s), pat(a + 16, s), '0, '0, "");
  endtask

  // Output monitor: first word after k rise, second after kN rise, else deselected.
  always begin : monitor
    int idx;
    @(posedge k); #5;
    if (monOn) begin
      idx = edgeCnt - 1;
      if (idx >= 0 && expValid[idx]) begin
        chk(oe === 1'b1, "R2", "oe during burst", {35'd0, oe}, 36'd1);
        chk(dout === expW0[idx], expTag[idx], "first word", dout, expW0[idx]);
        @(posedge kN); #5;
        chk(dout === expW1[idx], expTag[idx], "second word", dout, expW1[idx]);
      end else begin
        chk(oe === 1'b0, "R8", "oe idle", {35'd0, oe}, 36'd0);
      end
    end
  end

  task automatic testReset;
    chk(oe === 1'b0, "R8", "oe in reset", {35'd0, oe}, 36'd0);
  endtask

  task automatic testEcho;
    @(posedge k); #3;
    chk(cq === 1'b1 && cqN === 1'b0, "R4", "echo high phase", {34'd0, cq, cqN}, 36'b10);
    @(posedge kN); #3;
    chk(cq === 1'b0 && cqN === 1'b1, "R4", "echo low phase", {34'd0, cq, cqN}, 36'b01);
  endtask

  task automatic testSingle(input int s);
    wrPair(3, s);
    doCycle(1, 3, 0, 0, '0, '0, '1, '1, "R10");
    idle(2);
    doCycle(1, 3, 0, 0, '0, '0, '1, '1, "R1 R5");
    idle(3);
  endtask

  task automatic testStream(input int s);
    for (int a = 8; a < 12; a++) wrPair(a, s);
    for (int a = 8; a < 12; a++) doCycle(1, a, 0, 0, '0, '0, '1, '1, "R3");
    doCycle(1, 8, 1, 9, pat(1, s), pat(2, s), '0, '0, "R3");
    idle(3);
  endtask

  task automatic testLanes(input int s);
    wrPair(12, s);
    doCycle(0, 0, 1, 12, pat(40, s), pat(41, s), 4'b1010, 4'b0101, "");
    doCycle(1, 12, 0, 0, '0, '0, '1, '1, "R6");
    doCycle(0, 0, 1, 12, pat(42, s), pat(43, s), 4'b1111, 4'b0111, "");
    doCycle(1, 12, 0, 0, '0, '0, '1, '1, "R6");
    idle(3);
  endtask

  task automatic testIgnored(input int s);
    wrPair(5, s);
    doCycle(0, 0, 0, 5, pat(77, s), pat(78, s), '0, '0, "");
    doCycle(1, 5, 0, 0, '0, '0, '1, '1, "R7");
    idle(3);
  endtask

  task automatic testSameCycle(input int s);
    wrPair(6, s);
    doCycle(1, 6, 1, 6, pat(90, s), pat(91, s), '0, '0, "R9");
    doCycle(1, 6, 0, 0, '0, '0, '1, '1, "R9 R10");
    idle(3);
  endtask

  task automatic runAll(input int s);
    testEcho();
    testSingle(s);
    testStream(s);
    testLanes(s);
    testIgnored(s);
    testSameCycle(s);
  endtask

  initial begin
    rstN = 1'b0; rdSelN = 1'b1; wrSelN = 1'b1; addr = '0; din = '0; byteWrN = '1;
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(posedge k);
    #5 testReset();
    rstN = 1'b1;
    monOn = 1'b1;
    for (int a = 0; a < 16; a++) wrPair(a, 0);
    runAll(1);
    tied = 1'b1;           // R4: output timing from k/kN
    idle(2);
    runAll(2);
    idle(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule